// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block stands in for a small serial EEPROM. It sits on a three-wire serial link made of a chip select, a shift clock and one data line into the device, plus one data line out. A fast system clock oversamples the three input pins. The block frames each command and decodes it, then carries out the command against an internal array of 64 sixteen-bit words. A static strap input decides whether that array is seen as 64 words of 16 bits or as 128 words of 8 bits.

Commands that program the array are refused until an enable command has set an internal latch. Each programming command that is accepted starts a self-timed busy period of `PROG_CYCLES` system clocks. The host can poll for the end of that period: it drops chip select and raises it again, and the data output then shows busy (0) or ready (1). The output-enable signal models the high-impedance state of the data output pin.

Top module: `serial_eeprom_emu`

## Requirements
- R1: While chip select is high and no command is in progress, 0 bits clocked in are ignored. The first 1 bit is the start bit. It is followed by a two-bit opcode and then the address, both most significant bit first. Every bit is sampled on a rising shift-clock edge.
- R2: The opcodes are 10 for read, 01 for write and 11 for erase. Opcode 00 is a special command chosen by the two most significant address bits: 11 sets the programming-enable latch, 00 clears it, 10 erases the whole array, and 01 writes one data word to every location.
- R3: With `org_wide`=1 the address has 6 bits and the data has 16 bits. With `org_wide`=0 the address has 7 bits and the data has 8 bits. Address bit 0 then picks one byte of the 16-bit word at address[6:1]: 0 picks bits 7:0 and 1 picks bits 15:8.
- R4: Reset clears the programming-enable latch. While the latch is clear, write, erase, erase-all and write-all leave the array unchanged and start no busy period. Once set, the latch stays set until a disable command is received.
- R5: A read returns the stored data whatever the state of the programming-enable latch.
- R6: After the last address bit of a read, the output shows a 0 dummy bit. Each following rising shift-clock edge then moves out the next data bit, MSB first. The rising edge after the last data bit turns the output enable off.
- R7: Erase sets every bit of the addressed word or byte to 1. Erase-all sets every bit in the array to 1. In 8-bit organisation, write-all stores the supplied byte in every byte.
- R8: The status phase starts when chip select rises while a busy period is running. In that phase the output enable is 1 and the data output is 0 while busy and 1 once ready. When chip select rises with no busy period running, the output enable stays 0.
- R9: A busy period begins when the last bit of the command is decoded: the last data bit for a write or write-all, the last address bit for an erase or erase-all. It lasts `PROG_CYCLES` system clocks.
- R10: Commands clocked in during a busy period are ignored and do not change the array.
- R11: The output enable is 0 whenever chip select is low, and it is 0 outside a read or status phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_wide | input | 1 | Organisation strap: 1 selects 16-bit words, 0 selects 8-bit words |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial shift clock |
| sdin | input | 1 | Serial data into the device |
| sdout | output | 1 | Serial data out: read bits or ready/busy status |
| sdout_en | output | 1 | Output enable for `sdout`; 0 models high impedance |

## Verification
A wrong bit or byte lane in the array, or a lost write, shows up on the next read of that location as a wrong bit in the serial data. It appears within one word time of the read. A programming-enable latch in the wrong state, or a command accepted while busy, is first seen when the affected location is read back. Both can also show up at once as a missing or extra busy phase on the next chip-select toggle. A busy counter with the wrong length moves the busy-to-ready transition of the status output, and the bench samples that output a few clocks before and after the expected end.

// File: rtl/serial_eeprom_emu_pkg.sv
package serial_eeprom_emu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPC    = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DATA   = 3'd3,
        ST_READ   = 3'd4,
        ST_STATUS = 3'd5,
        ST_DONE   = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        WM_NONE = 2'd0,
        WM_WORD = 2'd1,
        WM_ALL  = 2'd2
    } wmode_e;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_lvl
);
    logic [W-1:0] meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= pin_raw;
            stab_q <= meta_q;
        end
    end

    assign pin_lvl = stab_q;
endmodule

// File: rtl/eeprom_word_array.sv
module eeprom_word_array
    import serial_eeprom_emu_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int IW    = $clog2(WORDS),
    localparam int HW    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wmode_e            wr_mode,
    input  logic [IW-1:0]     wr_idx,
    input  logic [1:0]        wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (wr_mode == WM_ALL || (wr_mode == WM_WORD && wr_idx == IW'(w))) begin
                if (wr_lane[0]) mem_q[w][HW-1:0]     <= wr_data[HW-1:0];
                if (wr_lane[1]) mem_q[w][DATA_W-1:HW] <= wr_data[DATA_W-1:HW];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    // R3: every accepted write touches at least one byte lane
    assert_lane_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode != WM_NONE) |-> (wr_lane != 2'b00));
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu
    import serial_eeprom_emu_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide,
    input  logic csel,
    input  logic sclk,
    input  logic sdin,
    output logic sdout,
    output logic sdout_en
);
    localparam int IW   = $clog2(WORDS);
    localparam int AW16 = IW;
    localparam int AW8  = IW + 1;
    localparam int HW   = DATA_W / 2;
    localparam int CW   = $clog2(DATA_W + 1);
    localparam int PW   = $clog2(PROG_CYCLES + 1);
    localparam logic [PW-1:0] PROG_LOAD = PW'(PROG_CYCLES);

    typedef struct packed {
        phase_e            st;
        opcode_e           op;
        logic [AW8-1:0]    addr;
        logic [DATA_W-1:0] data;
        logic [CW-1:0]     cnt;
        logic [DATA_W:0]   shr;
        logic              en;
        logic [PW-1:0]     prog;
        logic              csel_prev;
        logic              sclk_prev;
    } regs_t;

    regs_t q, n;

    logic [2:0] pins_s;
    logic csel_s, sclk_s, sdin_s, csel_rise, sclk_rise, busy;
    logic [AW8-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh, rd_word;
    logic [HW-1:0] rd_byte;
    logic [IW-1:0] rd_idx, wr_idx;
    logic [1:0] wr_lane, spec;
    logic [DATA_W-1:0] wr_data;
    wmode_e wr_mode;
    logic [CW-1:0] aw_last, dw_last, dw_full;

    eeprom_pin_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_raw({sdin, sclk, csel}),
        .pin_lvl(pins_s)
    );

    assign csel_s    = pins_s[0];
    assign sclk_s    = pins_s[1];
    assign sdin_s    = pins_s[2];
    assign csel_rise = csel_s & ~q.csel_prev;
    assign sclk_rise = sclk_s & ~q.sclk_prev;
    assign busy      = (q.prog != '0);

    function automatic logic [IW-1:0] word_of(input logic [AW8-1:0] a);
        return org_wide ? a[IW-1:0] : a[AW8-1:1];
    endfunction

    function automatic logic [1:0] lane_of(input logic [AW8-1:0] a);
        return org_wide ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
    endfunction

    assign addr_sh = {q.addr[AW8-2:0], sdin_s};
    assign data_sh = {q.data[DATA_W-2:0], sdin_s};
    assign rd_idx  = word_of(addr_sh);
    assign rd_byte = addr_sh[0] ? rd_word[DATA_W-1:HW] : rd_word[HW-1:0];
    assign spec    = org_wide ? addr_sh[AW16-1 -: 2] : addr_sh[AW8-1 -: 2];
    assign aw_last = org_wide ? CW'(AW16 - 1) : CW'(AW8 - 1);
    assign dw_last = org_wide ? CW'(DATA_W - 1) : CW'(HW - 1);
    assign dw_full = org_wide ? CW'(DATA_W) : CW'(HW);

    eeprom_word_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_mode(wr_mode),
        .wr_idx (wr_idx),
        .wr_lane(wr_lane),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_word)
    );

    always_comb begin
        n           = q;
        n.csel_prev = csel_s;
        n.sclk_prev = sclk_s;
        wr_mode     = WM_NONE;
        wr_idx      = word_of(q.addr);
        wr_lane     = lane_of(q.addr);
        wr_data     = '1;
        if (busy) n.prog = q.prog - 1'b1;

        if (!csel_s) begin
            n.st = ST_IDLE;
        end else if (csel_rise) begin
            n.st  = busy ? ST_STATUS : ST_IDLE;
            n.cnt = '0;
        end else if (sclk_rise) begin
            unique case (q.st)
                ST_IDLE, ST_STATUS: begin
                    if (sdin_s && !busy) begin
                        n.st  = ST_OPC;
                        n.cnt = '0;
                    end
                end
                ST_OPC: begin
                    n.op  = opcode_e'({q.op[0], sdin_s});
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CW'(1)) begin
                        n.st  = ST_ADDR;
                        n.cnt = '0;
                    end
                end
                ST_ADDR: begin
                    n.addr = addr_sh;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == aw_last) begin
                        n.cnt = '0;
                        n.st  = ST_DONE;
                        unique case (q.op)
                            OP_READ: begin
                                n.st  = ST_READ;
                                n.shr = org_wide ? {1'b0, rd_word} : {1'b0, rd_byte, {HW{1'b0}}};
                            end
                            OP_WRITE: begin
                                n.st   = ST_DATA;
                                n.data = '0;
                            end
                            OP_ERASE: begin
                                if (q.en) begin
                                    wr_mode = WM_WORD;
                                    wr_idx  = word_of(addr_sh);
                                    wr_lane = lane_of(addr_sh);
                                    n.prog  = PROG_LOAD;
                                end
                            end
                            default: begin
                                unique case (spec)
                                    2'b11: n.en = 1'b1;
                                    2'b00: n.en = 1'b0;
                                    2'b10: begin
                                        if (q.en) begin
                                            wr_mode = WM_ALL;
                                            wr_lane = 2'b11;
                                            n.prog  = PROG_LOAD;
                                        end
                                    end
                                    default: begin
                                        n.st   = ST_DATA;
                                        n.data = '0;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    n.data = data_sh;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == dw_last) begin
                        n.st  = ST_DONE;
                        n.cnt = '0;
                        if (q.en) begin
                            n.prog  = PROG_LOAD;
                            wr_data = org_wide ? data_sh : {data_sh[HW-1:0], data_sh[HW-1:0]};
                            if (q.op == OP_WRITE) begin
                                wr_mode = WM_WORD;
                            end else begin
                                wr_mode = WM_ALL;
                                wr_lane = 2'b11;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (q.cnt == dw_full) begin
                        n.st = ST_DONE;
                    end else begin
                        n.shr = {q.shr[DATA_W-1:0], 1'b0};
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sdout_en = csel_s && (q.st == ST_READ || q.st == ST_STATUS);
    assign sdout    = (q.st == ST_STATUS) ? ~busy : q.shr[DATA_W];

    // R4: nothing reaches the array unless programming is enabled
    assert_write_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode != WM_NONE) |-> q.en);

    // R9: the busy counter only counts down once loaded
    assert_busy_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.prog != '0) |=> (q.prog == $past(q.prog) - 1'b1));

    // R10: no command reaches the array during a busy period
    assert_ignore_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.prog != '0) |-> (wr_mode == WM_NONE));

    // R6: entering the read phase presents the dummy zero
    assert_read_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ && $past(q.st) != ST_READ) |-> (sdout == 1'b0));

    // R11: a low chip select turns the output driver off by the next cycle
    assert_oe_follows_csel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !csel_s |=> !sdout_en);
endmodule

// File: tb/serial_eeprom_emu_test.sv
module serial_eeprom_emu_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int PROG       = 600;
    localparam int WD_CYCLES  = 195000;
    localparam logic [1:0] OP_SP = 2'b00, OP_WR = 2'b01, OP_RD = 2'b10, OP_ER = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0, org_wide = 1'b1;
    logic csel = 1'b0, sclk = 1'b0, sdin = 1'b0;
    logic sdout, sdout_en;

    int vectors = 0, miscompares = 0, cyc = 0, t_rise = 0;
    logic s_do, s_oe;
    logic [15:0] ref_mem [64];
    bit ref_en = 1'b0;
    bit done = 1'b0;

    serial_eeprom_emu #(.WORDS(64), .DATA_W(16), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .csel(csel),
        .sclk(sclk), .sdin(sdin), .sdout(sdout), .sdout_en(sdout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        sdin = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        t_rise = cyc;
        repeat (HALF) @(negedge clk);
        s_do = sdout;
        s_oe = sdout_en;
        sclk = 1'b0;
    endtask

    task automatic cs_on();
        csel = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        csel = 1'b0;
        sdin = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [6:0] spec_addr(input logic [1:0] code, input bit wide);
        return wide ? {1'b0, code, 4'b0} : {code, 5'b0};
    endfunction

    function automatic logic [15:0] exp_read(input logic [6:0] a, input bit wide);
        if (wide) return ref_mem[a[5:0]];
        return a[0] ? {8'h00, ref_mem[a[6:1]][15:8]} : {8'h00, ref_mem[a[6:1]][7:0]};
    endfunction

    function automatic void ref_word(input logic [6:0] a, input logic [15:0] v, input bit wide);
        if (wide) ref_mem[a[5:0]] = v;
        else if (a[0]) ref_mem[a[6:1]][15:8] = v[7:0];
        else ref_mem[a[6:1]][7:0] = v[7:0];
    endfunction

    function automatic void ref_update(input logic [1:0] op, input logic [6:0] a,
                                       input logic [15:0] d, input bit wide);
        logic [1:0] code = wide ? a[5:4] : a[6:5];
        case (op)
            OP_WR: ref_word(a, d, wide);
            OP_ER: ref_word(a, 16'hFFFF, wide);
            default: begin
                for (int w = 0; w < 64; w++) begin
                    if (code == 2'b10) ref_mem[w] = 16'hFFFF;
                    else if (code == 2'b01) ref_mem[w] = wide ? d : {d[7:0], d[7:0]};
                end
            end
        endcase
    endfunction

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a, input bit wide, input int lead);
        int aw = wide ? 6 : 7;
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1);
        sbit(op[1]);
        sbit(op[0]);
        for (int i = aw - 1; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d, input bit wide);
        int dw = wide ? 16 : 8;
        for (int i = dw - 1; i >= 0; i--) sbit(d[i]);
    endtask

    task automatic rd_check(input logic [6:0] a, input bit wide, input int lead, input string tag);
        logic [15:0] got = '0;
        int dw = wide ? 16 : 8;
        org_wide = wide;
        cs_on();
        send_hdr(OP_RD, a, wide, lead);
        chk("R6 dummy bit", {15'd0, s_do}, 16'h0000);
        for (int i = 0; i < dw; i++) begin
            sbit(1'b0);
            got = {got[14:0], s_do};
        end
        sbit(1'b0);
        chk("R6 output released after last bit", {15'd0, s_oe}, 16'h0000);
        chk(tag, got, exp_read(a, wide));
        cs_off();
    endtask

    task automatic spec_cmd(input logic [1:0] code, input bit wide);
        org_wide = wide;
        cs_on();
        send_hdr(OP_SP, spec_addr(code, wide), wide, 0);
        cs_off();
        if (code == 2'b11) ref_en = 1'b1;
        if (code == 2'b00) ref_en = 1'b0;
    endtask

    task automatic prog(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d,
                        input bit wide, input string tag);
        bit go = ref_en;
        bit has_data = (op == OP_WR) || (op == OP_SP && (wide ? a[5:4] : a[6:5]) == 2'b01);
        int tr;
        org_wide = wide;
        cs_on();
        send_hdr(op, a, wide, 0);
        if (has_data) send_data(d, wide);
        tr = t_rise;
        cs_off();
        cs_on();
        if (go) begin
            chk({"R8 busy status ", tag}, {14'd0, sdout_en, sdout}, 16'h0002);
            while (cyc < tr + PROG - 4) @(negedge clk);
            chk({"R9 still busy ", tag}, {14'd0, sdout_en, sdout}, 16'h0002);
            while (cyc < tr + PROG + 8) @(negedge clk);
            chk({"R9 ready ", tag}, {14'd0, sdout_en, sdout}, 16'h0003);
            ref_update(op, a, d, wide);
        end else begin
            chk({"R4 no busy phase ", tag}, {15'd0, sdout_en}, 16'h0000);
        end
        cs_off();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < 64; w++) ref_mem[w] = 16'h0000;
        repeat (5) @(negedge clk);
        chk("R11 reset output off", {15'd0, sdout_en}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle output off", {15'd0, sdout_en}, 16'h0000);

        // R4: latch clear after reset, erase-all refused
        prog(OP_SP, spec_addr(2'b10, 1'b1), 16'h0, 1'b1, "R4 eral locked");
        spec_cmd(2'b11, 1'b1);
        prog(OP_SP, spec_addr(2'b10, 1'b1), 16'h0, 1'b1, "R7 erase all");
        rd_check(7'd0, 1'b1, 0, "R7 erase all word 0");
        rd_check(7'd63, 1'b1, 1, "R7 erase all word 63");

        // R4 and R5: disabled write has no effect, read still works
        spec_cmd(2'b00, 1'b1);
        prog(OP_WR, 7'd5, 16'h1234, 1'b1, "R4 write locked");
        rd_check(7'd5, 1'b1, 0, "R5 read while disabled");

        // R1, R2: writes and reads with leading zeros
        spec_cmd(2'b11, 1'b1);
        for (int i = 0; i < 6; i++) begin
            logic [6:0] a = 7'($urandom_range(0, 63));
            prog(OP_WR, a, 16'($urandom), 1'b1, "R2 write");
            rd_check(a, 1'b1, i % 3, "R1 read back after leading zeros");
        end
        prog(OP_WR, 7'd9, 16'h8001, 1'b1, "R2 write edge bits");
        rd_check(7'd9, 1'b1, 0, "R6 msb and lsb order");

        // R7: single-word erase
        prog(OP_ER, 7'd9, 16'h0, 1'b1, "R7 erase word");
        rd_check(7'd9, 1'b1, 0, "R7 erased word reads ones");

        // R7: write-all in 16-bit organisation
        prog(OP_SP, spec_addr(2'b01, 1'b1), 16'hA5C3, 1'b1, "R7 write all");
        rd_check(7'd0, 1'b1, 0, "R7 write all word 0");
        rd_check(7'd42, 1'b1, 0, "R7 write all word 42");

        // R3: byte organisation
        prog(OP_WR, 7'd20, 16'h003C, 1'b0, "R3 low byte");
        prog(OP_WR, 7'd21, 16'h00E7, 1'b0, "R3 high byte");
        rd_check(7'd20, 1'b0, 0, "R3 byte 0 read");
        rd_check(7'd21, 1'b0, 0, "R3 byte 1 read");
        rd_check(7'd10, 1'b1, 0, "R3 bytes form word 10");
        prog(OP_ER, 7'd21, 16'h0, 1'b0, "R7 erase one byte");
        rd_check(7'd10, 1'b1, 0, "R7 byte erase keeps other lane");
        prog(OP_SP, spec_addr(2'b01, 1'b0), 16'h005A, 1'b0, "R7 write all bytes");
        rd_check(7'd127, 1'b0, 0, "R7 byte write all top byte");
        rd_check(7'd33, 1'b1, 0, "R7 byte write all both lanes");

        // R10: command during busy period is ignored
        begin
            int tr;
            org_wide = 1'b1;
            cs_on();
            send_hdr(OP_WR, 7'd12, 1'b1, 0);
            send_data(16'hBEEF, 1'b1);
            tr = t_rise;
            cs_off();
            cs_on();
            send_hdr(OP_WR, 7'd13, 1'b1, 0);
            send_data(16'h1111, 1'b1);
            chk("R10 status kept while busy", {14'd0, s_oe, s_do}, 16'h0002);
            while (cyc < tr + PROG + 8) @(negedge clk);
            cs_off();
            ref_update(OP_WR, 7'd12, 16'hBEEF, 1'b1);
            rd_check(7'd13, 1'b1, 0, "R10 busy command ignored");
            rd_check(7'd12, 1'b1, 0, "R10 first write kept");
        end

        // R8: no status phase without a busy period
        cs_on();
        repeat (4) @(negedge clk);
        chk("R8 no status when idle", {15'd0, sdout_en}, 16'h0000);
        cs_off();

        // random mix
        for (int i = 0; i < 30; i++) begin
            bit wide = 1'($urandom_range(0, 1));
            logic [6:0] a = wide ? 7'($urandom_range(0, 63)) : 7'($urandom_range(0, 127));
            int pick = $urandom_range(0, 9);
            if (pick < 4) prog(OP_WR, a, 16'($urandom), wide, "R2 random write");
            else if (pick == 4) prog(OP_ER, a, 16'h0, wide, "R7 random erase");
            else if (pick == 5) spec_cmd(ref_en ? 2'b00 : 2'b11, wide);
            rd_check(a, wide, $urandom_range(0, 2), "R3 random read");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule